// File: doc/BRIEF.md
# Output Pad Test-Mode Multiplexer

This block sits between a chip's functional logic and its output pads. It chooses what reaches each pad. In functional and boundary-scan operation, the core's data and enable values go to the pads unchanged. In the forced-output test, every pad is turned on and driven from one shared stimulus pin, so that a tester can measure the DC high and low levels of all outputs with a single toggling signal.

A test-type-select pin picks between boundary-scan use and the forced-output test. The pin that normally clocks the scan logic becomes the stimulus in the forced test. Neighbouring pads take opposite polarities, which sets up a checkerboard, so shorts between adjacent pads show up as contention. The select pin passes through a synchroniser before it can change the mode. A mode change waits while the scan logic reports that it is busy.

Top module: `pad_test_mux`

## Requirements
- R1: While reset is held, and after it is released with the select pin low, the block is in boundary-scan mode. Pads pass the functional values, and `scan_clk_o` follows `tclk_i`.
- R2: Outside forced mode, `pad_do_o` equals `func_do_i` and `pad_oe_o` equals `func_oe_i`, bit for bit, for any value.
- R3: When `tts_i` goes high and stays high with `scan_active_i` low, forced mode takes effect after the third rising clock edge. After only two edges, the pads still pass the functional values.
- R4: In forced mode, every bit of `pad_oe_o` is 1, whatever `func_oe_i` holds.
- R5: In forced mode, pad bit i equals `tclk_i` when i is even (bit 0 is even) and the inverse of `tclk_i` when i is odd. With N=16 this gives 16'h5555 when the stimulus is 1 and 16'hAAAA when it is 0. The path is combinational, so the pads follow a stimulus change within the same cycle.
- R6: In forced mode, `scan_clk_o` is held at 0.
- R7: While `scan_active_i` is high, the mode does not change, whatever the synchronised select value is. When `scan_active_i` drops, a pending change takes effect on the next rising edge.
- R8: When `tts_i` returns low for three rising edges with `scan_active_i` low, the block leaves forced mode, and pads pass the functional values again.
- R9: In forced mode, `func_do_i` has no effect on `pad_do_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tts_i | input | 1 | Test-type select: 0 for boundary scan, 1 for forced output. The board pull-down makes an open pin read 0 |
| tclk_i | input | 1 | Scan clock pin, used as the stimulus in forced mode |
| scan_active_i | input | 1 | High while the scan logic is busy; freezes the mode |
| func_do_i | input | N | Functional output data |
| func_oe_i | input | N | Functional output enables |
| pad_do_o | output | N | Data driven to the pads |
| pad_oe_o | output | N | Enables driven to the pads |
| scan_clk_o | output | 1 | Scan clock forwarded to the scan logic |

## Verification
The pass-through path is swept with all-zero, all-one, both alternating words, every walking one and a series of arithmetic words. Together these show that no bit is swapped, stuck or inverted. In forced mode, the same functional patterns are applied while the stimulus toggles. This shows that the pads depend only on the stimulus, that polarity alternates by index, and that the enables ignore the core. The mode timing is probed one edge before and on the edge it is due, with the busy indication both high and low. This tells apart a synchroniser that is too short from a busy freeze that is missing.

// File: rtl/pad_test_mux.sv
module pad_test_mux #(
  parameter int N           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tts_i,
  input  logic         tclk_i,
  input  logic         scan_active_i,
  input  logic [N-1:0] func_do_i,
  input  logic [N-1:0] func_oe_i,
  output logic [N-1:0] pad_do_o,
  output logic [N-1:0] pad_oe_o,
  output logic         scan_clk_o
);

  logic [SYNC_STAGES-1:0] sel_sync_q;
  logic                   forced_q;
  logic [N-1:0]           checker_do;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sync_q <= '0;
      forced_q   <= 1'b0;
    end else begin
      sel_sync_q <= {sel_sync_q[SYNC_STAGES-2:0], tts_i};
      if (!scan_active_i)
        forced_q <= sel_sync_q[SYNC_STAGES-1];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pad
    localparam bit INVERT = (i % 2) == 1;
    assign checker_do[i] = tclk_i ^ INVERT;
  end

  assign pad_do_o   = forced_q ? checker_do : func_do_i;
  assign pad_oe_o   = forced_q ? {N{1'b1}}  : func_oe_i;
  assign scan_clk_o = tclk_i & ~forced_q;

endmodule

// File: rtl/pad_test_mux_chk.sv
module pad_test_mux_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tclk_i,
  input logic         scan_active_i,
  input logic [N-1:0] func_do_i,
  input logic [N-1:0] func_oe_i,
  input logic [N-1:0] pad_do_o,
  input logic [N-1:0] pad_oe_o,
  input logic         scan_clk_o,
  input logic         forced_q
);

  function automatic logic [N-1:0] odd_bits();
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction

  localparam logic [N-1:0] ODD_MASK = odd_bits();

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !forced_q |-> (pad_do_o == func_do_i && pad_oe_o == func_oe_i));

  // R4
  all_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forced_q |-> (&pad_oe_o));

  // R5
  checkerboard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forced_q |-> ((pad_do_o ^ {N{tclk_i}}) == ODD_MASK));

  // R6
  scan_clk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forced_q |-> !scan_clk_o);

  // R7
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_active_i |=> $stable(forced_q));

endmodule

bind pad_test_mux pad_test_mux_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .tclk_i(tclk_i), .scan_active_i(scan_active_i),
  .func_do_i(func_do_i), .func_oe_i(func_oe_i), .pad_do_o(pad_do_o),
  .pad_oe_o(pad_oe_o), .scan_clk_o(scan_clk_o), .forced_q(forced_q)
);

// File: tb/pad_test_mux_tb.sv
module pad_test_mux_tb;
  localparam int N = 16;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tts = 1'b0;
  logic         tclk = 1'b0;
  logic         busy = 1'b0;
  logic [N-1:0] fdo = '0;
  logic [N-1:0] foe = '0;
  logic [N-1:0] pdo;
  logic [N-1:0] poe;
  logic         sclk;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pad_test_mux #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .tts_i(tts), .tclk_i(tclk), .scan_active_i(busy),
    .func_do_i(fdo), .func_oe_i(foe), .pad_do_o(pdo), .pad_oe_o(poe),
    .scan_clk_o(sclk)
  );

  function automatic logic [N-1:0] even_mask();
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (i % 2) == 0;
    return m;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pass(input string req);
    check({req, " data"}, pdo, fdo);
    check({req, " enable"}, poe, foe);
  endtask

  task automatic check_forced(input string req);
    logic [N-1:0] exp;
    exp = tclk ? even_mask() : ~even_mask();
    check({req, " data"}, pdo, exp);
    check({req, " enable"}, poe, '1);
    check({req, " sclk"}, {{(N-1){1'b0}}, sclk}, '0);
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pats [0:3];
    pats[0] = '0; pats[1] = '1; pats[2] = even_mask(); pats[3] = ~even_mask();
    fdo = 16'h1234; foe = 16'h0F0F; tclk = 1'b1;
    #(PERIOD * 2 + 1);
    // R1 during reset
    check_pass("R1 reset");
    check("R1 sclk", {{(N-1){1'b0}}, sclk}, {{(N-1){1'b0}}, 1'b1});
    @(negedge clk); rst_n = 1'b1;
    edges(3);
    check_pass("R1 after reset");
    tclk = 1'b0; #1;
    check("R1 sclk low", {{(N-1){1'b0}}, sclk}, '0);
    // R2 sweep
    for (int p = 0; p < 4; p++) begin
      fdo = pats[p]; foe = ~pats[p]; #1; check_pass("R2 fixed");
    end
    for (int b = 0; b < N; b++) begin
      fdo = N'(1) << b; foe = ~(N'(1) << b); #1; check_pass("R2 walk");
    end
    for (int k = 0; k < 32; k++) begin
      fdo = N'(k * 40503 + 7); foe = N'(k * 12345); #1; check_pass("R2 arith");
    end
    // R3 entry timing
    @(negedge clk); tts = 1'b1; foe = '0;
    edges(2);
    check_pass("R3 not yet");
    edges(1);
    check_forced("R3 entered");
    // R4 R5 R9 forced sweep with toggling stimulus
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 2; s++) begin
        fdo = pats[p]; foe = pats[p]; tclk = s[0]; #1;
        check_forced("R4 R5 R9 pattern");
      end
    end
    for (int k = 0; k < 16; k++) begin
      fdo = N'(k * 40503); foe = N'(k * 977); tclk = ~tclk; #1;
      check_forced("R5 R9 toggle");
    end
    tclk = 1'b1; #1; check_forced("R6 stim high");
    // R7 exit blocked while busy
    busy = 1'b1; tts = 1'b0; fdo = 16'hBEEF; foe = 16'h00FF;
    edges(6);
    check_forced("R7 held forced");
    busy = 1'b0;
    edges(1);
    check_pass("R7 released exit");
    // R7 entry blocked while busy
    busy = 1'b1; tts = 1'b1;
    edges(6);
    check_pass("R7 held pass");
    busy = 1'b0;
    edges(1);
    check_forced("R7 released entry");
    // R8 exit timing
    tts = 1'b0;
    edges(2);
    check_forced("R8 not yet");
    edges(1);
    check_pass("R8 exited");
    tclk = 1'b1; #1;
    check("R8 sclk", {{(N-1){1'b0}}, sclk}, {{(N-1){1'b0}}, 1'b1});
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule